// File: doc/BRIEF.md
# Chip-Selected Parallel/Serial-Load Shift Register

This block is a chain of storage stages that changes state only on the falling edge of its clock. Each falling edge does one of three things. It can hold the contents. It can load a whole word from the parallel input. It can shift the chain one place toward the top stage, taking a new bit from the serial input into the bottom stage. The serial output always shows the top stage. So a word loaded in parallel leaves most-significant bit first on the shifts that follow.

An active-low select input gates every operation. While it is high the contents are frozen, whatever the mode and data inputs are doing. A synchronous active-high reset, taken on the falling edge, clears the chain and overrides every other operation.

The select input must only rise while the clock is low. A protocol monitor watches for a rise that happens while the clock is high. When it sees one, it sets a sticky violation flag, which stays set until reset.

Top module: `shsr_top`

## Requirements
- R1: Stage contents and the serial output change only on a falling edge of `clk`; a rising edge leaves `ser_out` unchanged even when the inputs change before it.
- R2: When `sel_n` is 1 on a falling edge and `rst` is 0, every stage keeps its value, regardless of `load_mode`, `ser_in` and `par_in`.
- R3: When `sel_n` is 0 and `load_mode` is 1 on a falling edge, stage i takes `par_in[i]` for every i from 0 to WIDTH-1.
- R4: When `sel_n` is 0 and `load_mode` is 0 on a falling edge, stage i+1 takes the old value of stage i, and stage 0 takes `ser_in`.
- R5: `ser_out` equals the top stage (WIDTH-1). After a parallel load, `par_in[WIDTH-1]` appears first, and lower bits follow in descending order on successive shifts.
- R6: `rst` = 1 on a falling edge clears every stage and the violation flag to 0, even when a load or shift is requested on the same edge.
- R7: If `sel_n` rises from 0 to 1 while `clk` is high, `cs_violation` becomes 1 after the next falling edge. It then stays 1 until a reset edge.
- R8: A rise of `sel_n` while `clk` is low does not set `cs_violation`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state updates on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| sel_n | input | 1 | Active-low select; 1 freezes the register |
| load_mode | input | 1 | 1 = parallel load, 0 = shift toward the top stage |
| ser_in | input | 1 | Serial bit written into stage 0 on a shift |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i on a load |
| ser_out | output | 1 | Value of the top stage |
| cs_violation | output | 1 | Sticky flag for a select rise taken while the clock was high |

## Verification
Two pairs of functions can meet on one falling edge, and the bench provokes each pair directly.

- **Reset against a load.** The bench asserts reset with select low, load mode high and an all-ones word. It then judges the outcome by shifting out a full word of zeros with a cleared flag.
- **Protocol flag against a hold.** An illegal select rise during the high phase makes the same falling edge both freeze the chain and set the flag. The bench judges this by requiring the flag to be set while the serial output and the later shifted-out contents match a model that treated that edge as a hold.

A legal rise during the low phase is driven just before, so a flag set at the wrong phase is caught.

// File: rtl/shsr_pkg.sv
package shsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } shsr_op_e;
endpackage

// File: rtl/shsr_ctrl.sv
module shsr_ctrl
  import shsr_pkg::*;
(
  input  logic     rst,
  input  logic     sel_n,
  input  logic     load_mode,
  output shsr_op_e op
);
  // Priority: reset, then select, then mode.
  always_comb begin
    if (rst)            op = OP_CLEAR;
    else if (sel_n)     op = OP_HOLD;
    else if (load_mode) op = OP_LOAD;
    else                op = OP_SHIFT;
  end
endmodule

// File: rtl/shsr_stage_array.sv
module shsr_stage_array
  import shsr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  shsr_op_e         op,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic shift_src;
    logic stage_r;

    if (i == 0) begin : g_bottom
      assign shift_src = ser_in;
    end else begin : g_upper
      assign shift_src = q[i-1];
    end

    always_ff @(negedge clk) begin
      case (op)
        OP_CLEAR: stage_r <= 1'b0;
        OP_LOAD:  stage_r <= par_in[i];
        OP_SHIFT: stage_r <= shift_src;
        default:  stage_r <= stage_r;
      endcase
    end

    assign q[i] = stage_r;
  end
endmodule

// File: rtl/shsr_cs_monitor.sv
module shsr_cs_monitor (
  input  logic clk,
  input  logic rst,
  input  logic sel_n,
  output logic violation
);
  // Select level at the start of the high phase.
  logic sel_at_rise;

  always_ff @(posedge clk) begin
    if (rst) sel_at_rise <= 1'b1;
    else     sel_at_rise <= sel_n;
  end

  // Low at the rising edge and high at the falling edge means it rose while clk was high.
  always_ff @(negedge clk) begin
    if (rst)                         violation <= 1'b0;
    else if (sel_n && !sel_at_rise)  violation <= 1'b1;
  end
endmodule

// File: rtl/shsr_top.sv
module shsr_top
  import shsr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             load_mode,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             cs_violation
);
  localparam int TOP = WIDTH - 1;

  shsr_op_e         op;
  logic [WIDTH-1:0] stage_q;

  shsr_ctrl ctrl_i (
    .rst       (rst),
    .sel_n     (sel_n),
    .load_mode (load_mode),
    .op        (op)
  );

  shsr_stage_array #(.WIDTH(WIDTH)) stages_i (
    .clk    (clk),
    .op     (op),
    .ser_in (ser_in),
    .par_in (par_in),
    .q      (stage_q)
  );

  shsr_cs_monitor mon_i (
    .clk       (clk),
    .rst       (rst),
    .sel_n     (sel_n),
    .violation (cs_violation)
  );

  assign ser_out = stage_q[TOP];
endmodule

// File: rtl/shsr_checker.sv
module shsr_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             sel_n,
  input logic             load_mode,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage_q,
  input logic             cs_violation
);
  assert_hold_R2: assert property (@(negedge clk) disable iff (rst)
    (sel_n) |=> $stable(stage_q));

  assert_load_R3: assert property (@(negedge clk) disable iff (rst)
    (!sel_n && load_mode) |=> (stage_q == $past(par_in)));

  assert_shift_R4: assert property (@(negedge clk) disable iff (rst)
    (!sel_n && !load_mode) |=> (stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_in)}));

  assert_reset_clears_R6: assert property (@(negedge clk) disable iff (rst)
    $past(rst) |-> (stage_q == '0 && !cs_violation));

  assert_flag_sticky_R7: assert property (@(negedge clk) disable iff (rst)
    cs_violation |=> cs_violation);

  assert_flag_cause_R7: assert property (@(negedge clk) disable iff (rst)
    $rose(cs_violation) |-> $past(sel_n));
endmodule

bind shsr_top shsr_checker #(.WIDTH(WIDTH)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .sel_n        (sel_n),
  .load_mode    (load_mode),
  .ser_in       (ser_in),
  .par_in       (par_in),
  .stage_q      (stage_q),
  .cs_violation (cs_violation)
);

// File: tb/shsr_top_tb_top.sv
`timescale 1ns/1ps
module shsr_top_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sel_n = 1'b1;
  logic         load_mode = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out;
  logic         cs_violation;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] model = '0;
  logic         model_flag = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  shsr_top #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .sel_n(sel_n), .load_mode(load_mode),
    .ser_in(ser_in), .par_in(par_in), .ser_out(ser_out),
    .cs_violation(cs_violation)
  );

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Apply inputs while clk is low, take one falling edge, update the model.
  task automatic tick(input logic r, input logic s, input logic m, input logic si,
                      input logic [W-1:0] d);
    rst = r; sel_n = s; load_mode = m; ser_in = si; par_in = d;
    @(negedge clk);
    if (r)       begin model = '0; model_flag = 1'b0; end
    else if (s)  model = model;
    else if (m)  model = d;
    else         model = {model[W-2:0], si};
    #1;
  endtask

  task automatic check_out(input string req);
    check(ser_out == model[W-1], req, {{(W-1){1'b0}}, ser_out},
          {{(W-1){1'b0}}, model[W-1]});
  endtask

  // Shift the whole word out with zeros behind it and compare every bit.
  task automatic drain(input string req);
    for (int i = 0; i < W; i++) begin
      check_out(req);
      tick(1'b0, 1'b0, 1'b0, 1'b0, $urandom);
    end
  endtask

  task automatic t_reset();
    tick(1'b1, 1'b1, 1'b0, 1'b0, '0);
    tick(1'b1, 1'b1, 1'b0, 1'b0, '0);
    check(cs_violation == 1'b0, "R6 flag after reset", {15'b0, cs_violation}, '0);
    drain("R6 stages zero after reset");
  endtask

  task automatic t_load_shift(input logic [W-1:0] word, input logic [W-1:0] pat);
    tick(1'b0, 1'b0, 1'b1, 1'b0, word);
    check(ser_out == word[W-1], "R3/R5 MSB first after load", {15'b0, ser_out},
          {15'b0, word[W-1]});
    for (int i = 0; i < W; i++) begin
      tick(1'b0, 1'b0, 1'b0, pat[W-1-i], $urandom);
      check_out("R4 shift toward top stage");
    end
    check(model == pat, "R4 model holds pattern", model, pat);
    drain("R4 shifted-in pattern emerges");
  endtask

  task automatic t_hold_mid(input logic [W-1:0] word);
    tick(1'b0, 1'b0, 1'b1, 1'b0, word);
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b0, 1'b0, 1'b1, '0);
    for (int i = 0; i < 4; i++) begin
      logic prev;
      prev = ser_out;
      tick(1'b0, 1'b1, i[0], ~i[0], $urandom);
      check(ser_out == prev, "R2 hold keeps output", {15'b0, ser_out}, {15'b0, prev});
    end
    drain("R2 contents intact after hold");
  endtask

  task automatic t_single_bit();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 16'h0001);
    for (int i = 0; i < W - 1; i++) begin
      check(ser_out == 1'b0, "R4 lone bit not yet at top", {15'b0, ser_out}, '0);
      tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
    end
    check(ser_out == 1'b1, "R4/R5 lone bit reaches top after W-1 shifts",
          {15'b0, ser_out}, 16'h1);
  endtask

  task automatic t_rising_edge();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 16'h8000);
    rst = 1'b0; sel_n = 1'b0; load_mode = 1'b1; par_in = 16'h0000;
    @(posedge clk); #1;
    check(ser_out == 1'b1, "R1 no change on rising edge", {15'b0, ser_out}, 16'h1);
    @(negedge clk); model = '0; #1;
    check(ser_out == 1'b0, "R1 change on falling edge", {15'b0, ser_out}, '0);
  endtask

  task automatic t_reset_override();
    tick(1'b0, 1'b0, 1'b1, 1'b0, 16'h1234);
    tick(1'b1, 1'b0, 1'b1, 1'b1, 16'hFFFF);
    check(ser_out == 1'b0, "R6 reset beats load", {15'b0, ser_out}, '0);
    drain("R6 reset beats load, all stages zero");
  endtask

  task automatic t_violation(input logic [W-1:0] word);
    tick(1'b0, 1'b0, 1'b1, 1'b0, word);
    sel_n = 1'b1;                       // legal rise: clk is low here
    @(negedge clk); #1;
    check(cs_violation == 1'b0, "R8 legal rise no flag", {15'b0, cs_violation}, '0);
    tick(1'b0, 1'b0, 1'b0, 1'b1, '0);
    @(posedge clk); #1;
    sel_n = 1'b1;                       // illegal rise: clk is high
    @(negedge clk); #1;
    check(cs_violation == 1'b1, "R7 flag on rise while clk high",
          {15'b0, cs_violation}, 16'h1);
    check_out("R7/R2 edge with violation still holds");
    tick(1'b0, 1'b0, 1'b0, 1'b0, '0);
    tick(1'b0, 1'b1, 1'b0, 1'b0, '0);
    check(cs_violation == 1'b1, "R7 flag sticky", {15'b0, cs_violation}, 16'h1);
    drain("R7 contents after violation");
    tick(1'b1, 1'b1, 1'b0, 1'b0, '0);
    check(cs_violation == 1'b0, "R6 reset clears flag", {15'b0, cs_violation}, '0);
  endtask

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_load_shift(16'hA5C3, 16'h0F1E);
    for (int k = 0; k < 4; k++) t_load_shift($urandom, $urandom);
    t_hold_mid(16'hC0DE);
    t_single_bit();
    t_rising_edge();
    t_reset_override();
    t_violation(16'h9AB7);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule